// File: doc/BRIEF.md
# Synthesizer Register Programming Sequencer

This block loads a fractional-N frequency synthesizer. It steps through a fixed, ordered list of 32-bit command words. Each word holds a 4-bit register address in bits [31:28] and 28 data bits in [27:0]. The block issues each word as a single write on a memory-mapped master port, and the slave can stall that port with a wait-request signal.

Address code 0xF is not a register. It tells the block to pause for a fixed number of clock cycles and write nothing. A word made of all ones ends the list. When the block reaches that word it stops and raises `done`.

There are two lists:
- **Power-up list.** It starts by itself right after reset.
- **Retune list.** It is shorter and starts on request.

Both lists fill in the values the block captures from its input pins when the list starts: the output divider, the integer part, both fraction parts and the modulus. The configuration words that stay fixed are parameters.

Top module: `synth_prog_seq`

## Requirements
- R1: While reset is held, `m_write` and `done` are 0. On the first cycle after reset is released, the power-up list starts without any request.
- R2: The power-up list writes registers 12, 11, 10, 9, 8, 7, 6, 5, 4, 3, 2 and 1, in that order. It then runs one delay entry and writes register 0 last, which is 13 writes in all.
  - The fixed registers carry their configuration parameter as data.
  - Register 4 carries its configuration parameter with bit 0 (counter reset) cleared.
- R3: Register 0 data is laid out as follows: integer value in bits [15:0], the prescaler parameter in bit [16], auto-calibration in bit [17], and zeros in bits [27:18].
  - Register 1 data is the 24-bit first fraction in bits [23:0], with zeros above.
  - Register 2 data is the 14-bit second fraction in bits [27:14] and the 14-bit modulus in bits [13:0].
- R4: Register 6 data is its configuration parameter with bits [19:17] replaced by the captured 3-bit divider select.
- R5: A command with address 0xF produces no write. With no wait states, the write that follows the delay is accepted DELAY_CYCLES+1 cycles after the write that came before it.
- R6: When the end word (all ones) is reached, `done` rises and no further write is issued. `done` is low from the first cycle of any list until that list's end.
- R7: The retune list writes the following, then ends:
  1. register 10;
  2. register 4 with bit 0 set;
  3. register 6;
  4. register 2;
  5. register 1;
  6. register 0 with auto-calibration 0;
  7. register 4 with bit 0 cleared;
  8. a delay;
  9. register 0 with auto-calibration 1.
- R8: While `m_waitrequest` is high, `m_write`, `m_address` and `m_writedata` hold steady. The list moves to its next entry only after a cycle with `m_write` high and `m_waitrequest` low. With no stalls, successive writes are accepted on consecutive cycles.
- R9: A retune request that arrives while a list is running is remembered. It starts as soon as the current list ends. The divider, integer, fraction and modulus inputs are sampled only when a list starts, so changing them while the list runs has no effect on its writes.
- R10: A one-cycle retune request while the block is idle starts the retune list on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retune_req | input | 1 | Request to run the retune list |
| div_sel | input | 3 | Output divider select |
| int_val | input | 16 | Integer divide value |
| frac1_val | input | 24 | First (main) fraction value |
| frac2_val | input | 14 | Second (auxiliary) fraction value |
| mod2_val | input | 14 | Auxiliary modulus value |
| m_write | output | 1 | Write strobe on the master port |
| m_address | output | 4 | Target register address |
| m_writedata | output | 28 | Register data |
| m_waitrequest | input | 1 | Slave stall; the write is accepted when low |
| done | output | 1 | High when the last started list has finished |

## Verification
The divider select is swept over all eight codes, one retune each. Each sweep step also uses a different integer, fraction and modulus value, so a misplaced field or a swapped bit shows up as a wrong data word.

The power-up run and the retune runs are each checked against a complete expected word list. This separates an ordering mistake from a field mistake.

Further cases:
- A second request posted during a running retune, with the inputs changed mid-list, tells a lost request apart from late input capture.
- A run with pseudo-random wait states separates correct strobe holding from skipped or repeated entries.
- Gaps measured around the delay entry check its length.

// File: rtl/synth_prog_seq.sv
module synth_prog_seq #(
  parameter int          DELAY_CYCLES = 4000,
  parameter logic        PRESCALER    = 1'b0,
  parameter logic [27:0] CFG_R12      = 28'h0000041,
  parameter logic [27:0] CFG_R11      = 28'h0061300,
  parameter logic [27:0] CFG_R10      = 28'h00C0193,
  parameter logic [27:0] CFG_R9       = 28'h110CF8C,
  parameter logic [27:0] CFG_R8       = 28'h102D402,
  parameter logic [27:0] CFG_R7       = 28'h1000066,
  parameter logic [27:0] CFG_R6       = 28'h353E048,
  parameter logic [27:0] CFG_R5       = 28'h0080000,
  parameter logic [27:0] CFG_R4       = 28'h20003B8,
  parameter logic [27:0] CFG_R3       = 28'h0000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retune_req,
  input  logic [2:0]  div_sel,
  input  logic [15:0] int_val,
  input  logic [23:0] frac1_val,
  input  logic [13:0] frac2_val,
  input  logic [13:0] mod2_val,
  output logic        m_write,
  output logic [3:0]  m_address,
  output logic [27:0] m_writedata,
  input  logic        m_waitrequest,
  output logic        done
);

  localparam int          DW       = $clog2(DELAY_CYCLES + 1);
  localparam logic [31:0] END_WORD = '1;
  localparam logic [3:0]  DLY_ADDR = 4'hF;

  logic          boot, busy, pend, retune;
  logic [3:0]    idx;
  logic [DW-1:0] dly_cnt;
  logic [2:0]    c_div;
  logic [15:0]   c_int;
  logic [23:0]   c_f1;
  logic [13:0]   c_f2, c_m2;
  logic [31:0]   cmd;

  wire [27:0] w_r6    = {CFG_R6[27:20], c_div, CFG_R6[16:0]};
  wire [27:0] w_r4_lo = {CFG_R4[27:1], 1'b0};
  wire [27:0] w_r4_hi = {CFG_R4[27:1], 1'b1};
  wire [27:0] w_r2    = {c_f2, c_m2};
  wire [27:0] w_r1    = {4'd0, c_f1};
  wire [27:0] w_r0_ac = {10'd0, 1'b1, PRESCALER, c_int};
  wire [27:0] w_r0_na = {10'd0, 1'b0, PRESCALER, c_int};

  always_comb begin
    cmd = END_WORD;
    if (!retune) begin
      case (idx)
        4'd0:  cmd = {4'hC, CFG_R12};
        4'd1:  cmd = {4'hB, CFG_R11};
        4'd2:  cmd = {4'hA, CFG_R10};
        4'd3:  cmd = {4'h9, CFG_R9};
        4'd4:  cmd = {4'h8, CFG_R8};
        4'd5:  cmd = {4'h7, CFG_R7};
        4'd6:  cmd = {4'h6, w_r6};
        4'd7:  cmd = {4'h5, CFG_R5};
        4'd8:  cmd = {4'h4, w_r4_lo};
        4'd9:  cmd = {4'h3, CFG_R3};
        4'd10: cmd = {4'h2, w_r2};
        4'd11: cmd = {4'h1, w_r1};
        4'd12: cmd = {DLY_ADDR, 28'd0};
        4'd13: cmd = {4'h0, w_r0_ac};
        default: cmd = END_WORD;
      endcase
    end else begin
      case (idx)
        4'd0: cmd = {4'hA, CFG_R10};
        4'd1: cmd = {4'h4, w_r4_hi};
        4'd2: cmd = {4'h6, w_r6};
        4'd3: cmd = {4'h2, w_r2};
        4'd4: cmd = {4'h1, w_r1};
        4'd5: cmd = {4'h0, w_r0_na};
        4'd6: cmd = {4'h4, w_r4_lo};
        4'd7: cmd = {DLY_ADDR, 28'd0};
        4'd8: cmd = {4'h0, w_r0_ac};
        default: cmd = END_WORD;
      endcase
    end
  end

  wire is_end = (cmd == END_WORD);
  wire is_dly = !is_end && (cmd[31:28] == DLY_ADDR);

  assign m_write     = busy && !is_end && !is_dly;
  assign m_address   = cmd[31:28];
  assign m_writedata = cmd[27:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot    <= 1'b1;
      busy    <= 1'b0;
      pend    <= 1'b0;
      retune  <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      dly_cnt <= '0;
      c_div   <= '0;
      c_int   <= '0;
      c_f1    <= '0;
      c_f2    <= '0;
      c_m2    <= '0;
    end else if (busy) begin
      if (retune_req) pend <= 1'b1;
      if (is_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (is_dly) begin
        if (dly_cnt == DW'(DELAY_CYCLES - 1)) begin
          dly_cnt <= '0;
          idx     <= idx + 4'd1;
        end else begin
          dly_cnt <= dly_cnt + DW'(1);
        end
      end else if (!m_waitrequest) begin
        idx <= idx + 4'd1;
      end
    end else if (boot || pend || retune_req) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      idx     <= '0;
      dly_cnt <= '0;
      retune  <= !boot;
      boot    <= 1'b0;
      pend    <= boot && (pend || retune_req);
      c_div   <= div_sel;
      c_int   <= int_val;
      c_f1    <= frac1_val;
      c_f2    <= frac2_val;
      c_m2    <= mod2_val;
    end
  end

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    m_write && m_waitrequest |=> m_write && $stable(m_address) && $stable(m_writedata)); // R8
  AST_NO_DELAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> m_address != DLY_ADDR); // R5
  AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dly_cnt < DW'(DELAY_CYCLES)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_write); // R6
  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !busy |=> busy && !done); // R9

endmodule

// File: tb/sim_synth_prog_seq.sv
module sim_synth_prog_seq;
  localparam int          DLY = 6;
  localparam logic        PRE = 1'b1;
  localparam logic [27:0] C12 = 28'h0C0C0C1, C11 = 28'h0B1B2B3, C10 = 28'h0A0A5A5;
  localparam logic [27:0] C9  = 28'h0909999, C8  = 28'h8888888, C7  = 28'h0770077;
  localparam logic [27:0] C6  = 28'hA5FFFF5, C5  = 28'h0505050, C4  = 28'h4444445;
  localparam logic [27:0] C3  = 28'h3030303;

  logic clk = 0, rst_n = 0, retune_req = 0, wr = 0;
  logic [2:0] div_sel = 0;
  logic [15:0] int_val = 0;
  logic [23:0] frac1_val = 0;
  logic [13:0] frac2_val = 0, mod2_val = 0;
  logic m_write, done;
  logic [3:0] m_address;
  logic [27:0] m_writedata;

  synth_prog_seq #(.DELAY_CYCLES(DLY), .PRESCALER(PRE), .CFG_R12(C12), .CFG_R11(C11),
    .CFG_R10(C10), .CFG_R9(C9), .CFG_R8(C8), .CFG_R7(C7), .CFG_R6(C6), .CFG_R5(C5),
    .CFG_R4(C4), .CFG_R3(C3)) u0 (
    .clk(clk), .rst_n(rst_n), .retune_req(retune_req), .div_sel(div_sel),
    .int_val(int_val), .frac1_val(frac1_val), .frac2_val(frac2_val), .mod2_val(mod2_val),
    .m_write(m_write), .m_address(m_address), .m_writedata(m_writedata),
    .m_waitrequest(wr), .done(done));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, nlog = 0, hold_viol = 0;
  logic [31:0] lw [0:63];
  int lc [0:63];
  bit stall = 0, prev_wait = 0;
  logic [7:0] lfsr = 8'h5B;
  logic [31:0] pw;
  logic [2:0]  ediv;
  logic [15:0] eint;
  logic [23:0] ef1;
  logic [13:0] ef2, em2;

  always @(negedge clk) begin
    cyc++;
    if (prev_wait && (!m_write || {m_address, m_writedata} != pw)) hold_viol++;
    if (stall) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr = lfsr[0] | lfsr[3];
    end else wr = 0;
    prev_wait = m_write && wr;
    pw = {m_address, m_writedata};
    if (rst_n && m_write && !wr) begin
      if (nlog < 64) begin lw[nlog] = {m_address, m_writedata}; lc[nlog] = cyc; end
      nlog++;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expw(bit ret, int k);
    logic [27:0] r6, r2, r1;
    r6 = {C6[27:20], ediv, C6[16:0]};
    r2 = {ef2, em2};
    r1 = {4'd0, ef1};
    if (!ret) begin
      case (k)
        0: return {4'hC, C12};  1: return {4'hB, C11};  2: return {4'hA, C10};
        3: return {4'h9, C9};   4: return {4'h8, C8};   5: return {4'h7, C7};
        6: return {4'h6, r6};   7: return {4'h5, C5};   8: return {4'h4, C4[27:1], 1'b0};
        9: return {4'h3, C3};  10: return {4'h2, r2};  11: return {4'h1, r1};
        default: return {4'h0, 10'd0, 1'b1, PRE, eint};
      endcase
    end
    case (k)
      0: return {4'hA, C10};
      1: return {4'h4, C4[27:1], 1'b1};
      2: return {4'h6, r6};
      3: return {4'h2, r2};
      4: return {4'h1, r1};
      5: return {4'h0, 10'd0, 1'b0, PRE, eint};
      6: return {4'h4, C4[27:1], 1'b0};
      default: return {4'h0, 10'd0, 1'b1, PRE, eint};
    endcase
  endfunction

  task automatic set_in(logic [2:0] d, logic [15:0] i, logic [23:0] f1, logic [13:0] f2, logic [13:0] m2);
    div_sel = d; int_val = i; frac1_val = f1; frac2_val = f2; mod2_val = m2;
  endtask

  task automatic expect_now();
    ediv = div_sel; eint = int_val; ef1 = frac1_val; ef2 = frac2_val; em2 = mod2_val;
  endtask

  task automatic wait_for(int target);
    int n = 0;
    while (!(done && nlog >= target) && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(0, "R6", "done timeout", 64'(nlog), 64'(target));
  endtask

  task automatic verify(bit ret, int base);
    int n = ret ? 8 : 13;
    for (int k = 0; k < n; k++) begin
      chk(lw[base+k] == expw(ret, k), ret ? "R7" : "R2", $sformatf("entry %0d", k),
          64'(lw[base+k]), 64'(expw(ret, k)));
      if (lw[base+k][31:28] == 4'h6)
        chk(lw[base+k][19:17] == ediv, "R4", "divider field", 64'(lw[base+k][19:17]), 64'(ediv));
      if (lw[base+k][31:28] == 4'h0)
        chk(lw[base+k][15:0] == eint && lw[base+k][16] == PRE, "R3", "reg0 int/prescaler",
            64'(lw[base+k][16:0]), 64'({PRE, eint}));
    end
  endtask

  task automatic pulse_retune();
    retune_req = 1;
    @(negedge clk);
    retune_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R6", "watchdog", 64'(nlog), 64'(0));
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    set_in(3'd5, 16'd91, 24'h800000, 14'd0, 14'd1);
    repeat (5) @(negedge clk);
    chk(m_write == 0, "R1", "write in reset", 64'(m_write), 64'(0));
    chk(done == 0, "R1", "done in reset", 64'(done), 64'(0));
    expect_now();
    nlog = 0;
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(m_write && !done, "R1", "power-up auto start", 64'({m_write, done}), 64'(2));
    wait_for(13);
    repeat (4) @(negedge clk);
    chk(nlog == 13, "R6", "power-up write count", 64'(nlog), 64'(13));
    chk(done == 1, "R6", "done after power-up", 64'(done), 64'(1));
    verify(0, 0);
    chk(lc[1] - lc[0] == 1, "R8", "back-to-back gap", 64'(lc[1] - lc[0]), 64'(1));
    chk(lc[12] - lc[11] == DLY + 1, "R5", "power-up delay gap", 64'(lc[12] - lc[11]), 64'(DLY + 1));

    for (int d = 0; d < 8; d++) begin
      set_in(3'(d), 16'(d * 4099 + 7), 24'(d * 1234567 + 3), 14'(d * 2011 + 1), 14'(16383 - d * 977));
      expect_now();
      nlog = 0;
      pulse_retune();
      chk(done == 0 && m_write == 1, "R10", "retune starts", 64'({done, m_write}), 64'(1));
      wait_for(8);
      repeat (3) @(negedge clk);
      chk(nlog == 8, "R6", "retune write count", 64'(nlog), 64'(8));
      verify(1, 0);
      chk(lc[7] - lc[6] == DLY + 1, "R5", "retune delay gap", 64'(lc[7] - lc[6]), 64'(DLY + 1));
    end

    set_in(3'd2, 16'h1234, 24'hABCDEF, 14'h0155, 14'h2AAA);
    expect_now();
    nlog = 0;
    pulse_retune();
    repeat (2) @(negedge clk);
    set_in(3'd6, 16'hBEEF, 24'h13579B, 14'h3C3C, 14'h0F0F);
    pulse_retune();
    wait_for(16);
    repeat (4) @(negedge clk);
    chk(nlog == 16, "R9", "latched request ran", 64'(nlog), 64'(16));
    verify(1, 0);
    expect_now();
    verify(1, 8);

    stall = 1;
    hold_viol = 0;
    set_in(3'd7, 16'hFFFF, 24'hFFFFFF, 14'h3FFF, 14'h0000);
    expect_now();
    nlog = 0;
    pulse_retune();
    wait_for(8);
    repeat (3) @(negedge clk);
    stall = 0;
    chk(nlog == 8, "R8", "stalled write count", 64'(nlog), 64'(8));
    verify(1, 0);
    chk(hold_viol == 0, "R8", "hold under wait", 64'(hold_viol), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule